// File: doc/BRIEF.md
# Polled byte-exchange SPI master

This block is a byte-wide SPI master that software runs by polling. It has three 16-bit registers. A control word enables the block and sets the serial-clock divisor, the clock idle level and the sampling phase. A store to the data register starts one full-duplex 8-bit exchange. The block drives SCLK and MOSI and shifts MISO in, most-significant bit first.

Software polls the status word until the busy flag drops and the receive-full flag rises. It then loads the data register to get the byte that came back, and that load clears the receive-full flag. Chip select comes from a separate general-purpose pin and is not part of this block.

An internal tick divides the peripheral clock so that each SCLK half period lasts divisor+1 clock cycles. The serial clock frequency is therefore PCLK / (2·(divisor+1)). Clearing the enable bit stops any exchange at once.

Top module: `spi_poll_master`

## Requirements
- R1: After reset the control word reads 0x0000, the status word reads 0x0000, SCLK is low and MOSI is low.
- R2: The control word sits at byte offset 2. Bit 0 is enable, bit 7 is the sampling phase, bit 8 is the SCLK idle level and bits 15:9 are the divisor (0 to 127). Bits 6:1 read as zero.
- R3: A store to offset 0 while enabled and idle starts an exchange. Status bit 0 (busy) then reads 1 for exactly 16·(divisor+1) clock cycles, counting from the cycle after the store.
- R4: During an exchange SCLK toggles every divisor+1 cycles, 16 times in all, and ends at its idle level.
- R5: While no exchange runs, SCLK equals control bit 8 (0 = idle low, 1 = idle high).
- R6: With phase bit 0, MOSI carries bit 7 of the byte from the first busy cycle. MISO is sampled on edges 1, 3, …, 15 and MOSI advances on edges 2, 4, …, 14.
- R7: With phase bit 1, MOSI advances on edges 3, 5, …, 15 and MISO is sampled on edges 2, 4, …, 16.
- R8: Bits go out and come in most-significant first. A load from offset 0 returns the received byte in bits 7:0, with bits 15:8 zero.
- R9: Status bit 1 (receive full) sets when the sixteenth edge completes. A load from offset 0 clears it.
- R10: A store to offset 0 while busy is ignored: the running exchange keeps its byte and its length.
- R11: A store to offset 0 while disabled starts nothing. Clearing enable during an exchange ends it one cycle later: busy reads 0, SCLK returns to idle and receive full is left unchanged.
- R12: The status word sits at offset 4. Every other offset reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Register store strobe |
| reg_rd | input | 1 | Register load strobe (side effects only) |
| reg_wdata | input | 16 | Store data |
| reg_rdata | output | 16 | Load data for the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Exchanges are run in all four clock modes with divisors of 0, 1, 2, 5 and 127. Each run uses different outgoing and incoming bytes, so a swapped sample edge, a wrong bit order or an off-by-one half period each give a different mismatch. One exchange receives a second store while busy, which separates an ignored store from one that reloads the shifter. Another is aborted by clearing enable, and a store is made while the block is disabled; together these show that enable gates both start and progress.

// File: rtl/spi_poll_pkg.sv
package spi_poll_pkg;
  localparam int REG_W  = 16;
  localparam int DIV_W  = 7;
  localparam int BYTE_W = 8;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_STAT = 3'd4;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             idle_hi;
    logic             late_smp;
    logic [5:0]       rsvd;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
  import spi_poll_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl
);
  ctrl_t ctrl_d, ctrl_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d      = ctrl_t'(wdata);
      ctrl_d.rsvd = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_d, cnt_q;

  assign tick = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && div != '0 |=> !tick || div != $past(div));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              late_smp,
  input  logic              start,
  input  logic [DATA_W-1:0] load,
  input  logic              tick,
  input  logic              miso,
  input  logic              rd_clr,
  output logic              busy,
  output logic              phase,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_full
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES + 1);
  localparam logic [EW-1:0] LAST = EW'(EDGES);
  localparam logic [EW-1:0] ONE  = EW'(1);

  logic              busy_d, busy_q, phase_d, phase_q, full_d, full_q;
  logic [EW-1:0]     edge_d, edge_q, edge_nx;
  logic [DATA_W-1:0] tx_d, tx_q, rx_d, rx_q, buf_d, buf_q;
  logic              step, is_last, odd, smp, lau;

  assign step    = busy_q && tick;
  assign edge_nx = edge_q + 1'b1;
  assign is_last = (edge_nx == LAST);
  assign odd     = edge_nx[0];
  assign smp     = late_smp ? !odd : odd;
  assign lau     = late_smp ? (odd && edge_nx != ONE) : (!odd && !is_last);

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    edge_d  = edge_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    buf_d   = buf_q;
    full_d  = full_q && !rd_clr;
    if (!en) begin
      busy_d  = 1'b0;
      phase_d = 1'b0;
      edge_d  = '0;
    end else if (step) begin
      phase_d = !phase_q;
      edge_d  = edge_nx;
      if (smp) rx_d = {rx_q[DATA_W-2:0], miso};
      if (lau) tx_d = {tx_q[DATA_W-2:0], 1'b0};
      if (is_last) begin
        busy_d = 1'b0;
        edge_d = '0;
        buf_d  = rx_d;
        full_d = 1'b1;
      end
    end else if (start && !busy_q) begin
      busy_d  = 1'b1;
      phase_d = 1'b0;
      edge_d  = '0;
      tx_d    = load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      edge_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      buf_q   <= '0;
      full_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      edge_q  <= edge_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      buf_q   <= buf_d;
      full_q  <= full_d;
    end
  end

  assign busy    = busy_q;
  assign phase   = phase_q;
  assign mosi    = busy_q && tx_q[DATA_W-1];
  assign rx_buf  = buf_q;
  assign rx_full = full_q;

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy_q);
  // R9
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && busy_q && tick && edge_q == LAST - 1'b1 |=> rx_full && !busy_q);
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && !busy_q |=> !rx_full);
  // R10
  wr_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && !tick |=> $stable(tx_q));
endmodule

// File: rtl/spi_poll_master.sv
module spi_poll_master
  import spi_poll_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic              wr_data, wr_ctrl, rd_data, tick, busy, phase, rx_full;
  logic [BYTE_W-1:0] rx_buf;
  ctrl_t             ctrl;

  assign wr_data = reg_wr && (reg_addr == A_DATA);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign rd_data = reg_rd && (reg_addr == A_DATA);

  spi_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync),
    .wr_en (wr_ctrl),
    .wdata (reg_wdata),
    .ctrl  (ctrl)
  );

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync),
    .run   (busy && ctrl.en),
    .div   (ctrl.div),
    .tick  (tick)
  );

  spi_shift_engine #(.DATA_W(BYTE_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_sync),
    .en       (ctrl.en),
    .late_smp (ctrl.late_smp),
    .start    (wr_data),
    .load     (reg_wdata[BYTE_W-1:0]),
    .tick     (tick),
    .miso     (miso),
    .rd_clr   (rd_data),
    .busy     (busy),
    .phase    (phase),
    .mosi     (mosi),
    .rx_buf   (rx_buf),
    .rx_full  (rx_full)
  );

  assign sclk = ctrl.idle_hi ^ phase;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DATA:  reg_rdata = {{(REG_W-BYTE_W){1'b0}}, rx_buf};
      A_CTRL:  reg_rdata = ctrl;
      A_STAT:  reg_rdata = {{(REG_W-2){1'b0}}, rx_full, busy};
      default: reg_rdata = '0;
    endcase
  end

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !busy |-> sclk == ctrl.idle_hi);
  // R12
  stat_view_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    reg_addr == A_STAT |-> reg_rdata[0] == busy && reg_rdata[REG_W-1:2] == '0);
endmodule

// File: tb/tb_spi_poll_master.sv
`timescale 1ns/1ps
module tb_spi_poll_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, miso = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic sclk, mosi;

  always #2.5 clk = ~clk;

  spi_poll_master dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  logic [15:0] m_ctrl = '0;
  bit m_busy = 0, m_phase = 0, m_full = 0;
  int m_cnt = 0, m_edge = 0;
  logic [7:0] m_tx = '0, m_rx = '0, m_buf = '0;
  logic [7:0] s_byte = '0, cap = '0;
  logic [15:0] last_rdata;
  logic prev_sclk = 1'b0;
  int toggles = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {8'h00, m_buf};
      3'd2: return m_ctrl;
      3'd4: return {14'h0, m_full, m_busy};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic slave_bit();
    int done = m_ctrl[7] ? m_edge / 2 : (m_edge + 1) / 2;
    return (done < 8) ? s_byte[7 - done] : 1'b0;
  endfunction

  task automatic model_step(input bit wr, input bit rd, input logic [2:0] a,
                            input logic [15:0] wd, input logic mi);
    int dv = int'(m_ctrl[15:9]);
    bit nfull = m_full;
    if (rd && a == 3'd0) nfull = 0;
    if (!m_ctrl[0]) begin
      m_busy = 0; m_phase = 0; m_edge = 0; m_cnt = 0;
    end else if (m_busy) begin
      if (m_cnt == dv) begin
        int k = m_edge + 1;
        bit smp = m_ctrl[7] ? (k % 2 == 0) : (k % 2 == 1);
        bit lau = m_ctrl[7] ? (k % 2 == 1 && k >= 3) : (k % 2 == 0 && k < 16);
        m_cnt = 0;
        m_phase = !m_phase;
        if (smp) m_rx = {m_rx[6:0], mi};
        if (lau) m_tx = {m_tx[6:0], 1'b0};
        if (k == 16) begin
          m_busy = 0; m_edge = 0; m_buf = m_rx; nfull = 1;
        end else m_edge = k;
      end else m_cnt++;
    end else if (wr && a == 3'd0) begin
      m_busy = 1; m_tx = wd[7:0]; m_edge = 0; m_phase = 0; m_cnt = 0;
    end
    m_full = nfull;
    if (wr && a == 3'd2) m_ctrl = wd & 16'hFF81;
  endtask

  task automatic cycle(input bit wr, input bit rd, input logic [2:0] a, input logic [15:0] wd);
    logic es, em;
    int k;
    @(negedge clk);
    es = m_phase ^ m_ctrl[8];
    em = m_busy ? m_tx[7] : 1'b0;
    chk(sclk === es, "R4 R5 sclk", int'(sclk), int'(es));
    chk(mosi === em, "R6 R7 mosi", int'(mosi), int'(em));
    if (sclk !== prev_sclk) toggles++;
    prev_sclk = sclk;
    k = m_edge + 1;
    if (m_ctrl[0] && m_busy && m_cnt == int'(m_ctrl[15:9]) &&
        (m_ctrl[7] ? (k % 2 == 0) : (k % 2 == 1)))
      cap = {cap[6:0], mosi};
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    miso = slave_bit();
    #1;
    last_rdata = reg_rdata;
    chk(last_rdata === exp_rd(a), "R2 R8 R9 R12 rdata", int'(last_rdata), int'(exp_rd(a)));
    model_step(wr, rd, a, wd, miso);
  endtask

  task automatic xfer(input bit cpol, input bit cpha, input int dv,
                      input logic [7:0] txb, input logic [7:0] sb, input bit extra);
    int bc = 0;
    cycle(1, 0, 3'd2, {7'(dv), cpol, cpha, 6'd0, 1'b1});
    cycle(0, 0, 3'd4, 16'h0);
    s_byte = sb; cap = '0; toggles = 0;
    cycle(1, 0, 3'd0, {8'h00, txb});
    for (int i = 0; i < 5000; i++) begin
      if (extra && i == 3) begin
        cycle(1, 0, 3'd0, {8'h00, ~txb});
        bc++;
      end else begin
        cycle(0, 0, 3'd4, 16'h0);
        if (last_rdata[0]) bc++;
        else break;
      end
    end
    chk(bc == 16 * (dv + 1), "R3 busy length", bc, 16 * (dv + 1));
    chk(toggles == 16, "R4 sclk edges", toggles, 16);
    chk(cap === txb, "R6 R7 R8 R10 mosi byte", int'(cap), int'(txb));
    chk(sclk === cpol, "R5 idle after", int'(sclk), int'(cpol));
    chk(last_rdata === 16'h0002, "R9 full set", int'(last_rdata), 2);
    cycle(0, 1, 3'd0, 16'h0);
    chk(last_rdata === {8'h00, sb}, "R8 rx byte", int'(last_rdata), int'(sb));
    cycle(0, 0, 3'd4, 16'h0);
    chk(last_rdata === 16'h0000, "R9 full cleared", int'(last_rdata), 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cycle(0, 0, 3'd4, 16'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) cycle(0, 0, 3'd4, 16'h0);
    // R1 reset state
    chk(sclk === 1'b0 && mosi === 1'b0, "R1 pins", int'({sclk, mosi}), 0);
    chk(last_rdata === 16'h0, "R1 status", int'(last_rdata), 0);
    cycle(0, 0, 3'd2, 16'h0);
    chk(last_rdata === 16'h0, "R1 ctrl", int'(last_rdata), 0);
    // R2 field layout
    cycle(1, 0, 3'd2, 16'hFFFF);
    cycle(0, 0, 3'd2, 16'h0);
    chk(last_rdata === 16'hFF81, "R2 ctrl readback", int'(last_rdata), 16'hFF81);
    chk(sclk === 1'b1, "R5 idle high", int'(sclk), 1);
    // R11 store while disabled
    cycle(1, 0, 3'd2, 16'h0000);
    cycle(1, 0, 3'd0, 16'h00FF);
    cycle(0, 0, 3'd4, 16'h0);
    chk(last_rdata === 16'h0, "R11 no start disabled", int'(last_rdata), 0);
    // R12 unmapped offsets
    cycle(0, 0, 3'd6, 16'h0);
    chk(last_rdata === 16'h0, "R12 offset 6", int'(last_rdata), 0);
    cycle(0, 0, 3'd1, 16'h0);
    chk(last_rdata === 16'h0, "R12 offset 1", int'(last_rdata), 0);
    // exchanges in all modes
    xfer(0, 0, 0, 8'hA5, 8'h3C, 0);
    xfer(0, 1, 2, 8'h96, 8'hC3, 0);
    xfer(1, 0, 1, 8'h01, 8'h80, 0);
    xfer(1, 1, 5, 8'h7E, 8'h5A, 0);
    xfer(0, 0, 3, 8'hE7, 8'h18, 1);  // R10 store while busy
    xfer(1, 1, 127, 8'h4D, 8'hB2, 0);
    // R11 abort by clearing enable
    cycle(1, 0, 3'd2, {7'd3, 1'b0, 1'b0, 6'd0, 1'b1});
    s_byte = 8'h81;
    cycle(1, 0, 3'd0, 16'h00C3);
    repeat (10) cycle(0, 0, 3'd4, 16'h0);
    cycle(1, 0, 3'd2, {7'd3, 9'd0});
    cycle(0, 0, 3'd4, 16'h0);
    cycle(0, 0, 3'd4, 16'h0);
    chk(last_rdata === 16'h0, "R11 abort status", int'(last_rdata), 0);
    chk(sclk === 1'b0, "R11 abort sclk idle", int'(sclk), 0);
    xfer(0, 1, 0, 8'h33, 8'hCC, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule